// File: doc/BRIEF.md
# Memory Initialization Address Sweeper

This block generates the full set of memory addresses covered by a run-time geometry and hands them out one by one as requests. Each request carries a DIMM, rank, bank, row and column index. The geometry arrives as an 11-bit word of small per-dimension size codes. The block decodes that word when a sweep is launched and keeps the decoded limits for the length of the pass. A code outside the legal set raises an error flag, and no sweep starts.

The block has two modes. In zero-fill mode every request is flagged as a write of all-zero data, and the block stops after the final address. In patrol mode the zero flag is low, so the same walk serves as the address source for background scrubbing. The walk restarts at address zero after each pass for as long as the mode input stays high. Requests leave on a valid/ready handshake, and a one-cycle done pulse marks the end of every pass. Two parameters set the base sizes that the column and row codes scale from.

Top module: `mem_init_sweeper`

## Requirements
- R1: Geometry word layout is cfg[1:0] column code, cfg[4:2] row code, cfg[6:5] bank code, cfg[8:7] rank code, cfg[10:9] DIMM code. Column code c gives 2^(COL_BASE_LOG2+c) columns. Row code r gives 2^(ROW_BASE_LOG2+r) rows. Bank codes 0/1/2 give 4/8/16 banks, rank codes 0/1/2 give 1/2/4 ranks, and DIMM codes 0/1/2 give 1/2/3 DIMMs.
- R2: A start seen while idle with any reserved code (column 3, row 5..7, bank 3, rank 3, DIMM 3) sets cfg_err to 1 and leaves req_valid and busy at 0.
- R3: Addresses are produced in nested order, with the column fastest, then row, then bank, then rank, and the DIMM slowest, each index counting up from 0.
- R4: The first request is valid in the cycle after start is sampled. The address advances only on a cycle with req_valid and req_ready both 1, and it holds steady while req_ready is 0.
- R5: In zero-fill mode (scrub_mode 0 at start), req_zero is 1 and every address within the limits is issued exactly once.
- R6: done is high for exactly one cycle, in the cycle after the final address is accepted. In zero-fill mode, req_valid and busy are 0 in that same cycle.
- R7: In patrol mode (scrub_mode 1 at start), req_zero is 0. If scrub_mode is still 1 when the final address is accepted, the walk restarts from address 0 with done pulsed. Otherwise the sweep ends as in R6.
- R8: start and cfg changes during a sweep are ignored; the running pass keeps the geometry latched at its start.
- R9: While rst is high and after it is released, req_valid, done, busy and cfg_err are 0.
- R10: A start with a legal geometry clears cfg_err to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a sweep when idle |
| scrub_mode | input | 1 | 1 selects patrol mode; its live value also decides the restart at pass end |
| cfg | input | 11 | Geometry code word |
| req_ready | input | 1 | Consumer accepts the current request |
| req_valid | output | 1 | Request address is valid |
| req_dimm | output | 2 | DIMM index |
| req_rank | output | 2 | Rank index |
| req_bank | output | 4 | Bank index |
| req_row | output | ROW_BASE_LOG2+4 | Row index |
| req_col | output | COL_BASE_LOG2+2 | Column index |
| req_zero | output | 1 | Request is an all-zero write |
| done | output | 1 | One-cycle end-of-pass pulse |
| busy | output | 1 | Sweep in progress |
| cfg_err | output | 1 | Last start carried a reserved code |

## Verification
The bench builds the block with COL_BASE_LOG2 = 1 and ROW_BASE_LOG2 = 1. Each dimension keeps its full set of codes, but the largest geometry shrinks to 49152 addresses. That makes it practical to walk the largest geometry end to end, including the top row code and three DIMMs, and to compare every address against an independent nested model. The same settings keep the short geometries small enough to cover randomized back-pressure, a disturbed start, and two patrol passes with the restart boundary.

// File: rtl/msw_pkg.sv
package msw_pkg;

    typedef struct packed {
        logic [1:0] dimm;
        logic [1:0] rank;
        logic [1:0] bank;
        logic [2:0] row;
        logic [1:0] col;
    } geom_code_t;

    localparam int CODE_W = $bits(geom_code_t);
    localparam int BANK_W = 4;
    localparam int RANK_W = 2;
    localparam int DIMM_W = 2;
    localparam logic [2:0] ROW_CODE_MAX = 3'd4;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_state_t;

    function automatic logic code_reserved(geom_code_t c);
        return (c.col == 2'b11) || (c.row > ROW_CODE_MAX) ||
               (c.bank == 2'b11) || (c.rank == 2'b11) || (c.dimm == 2'b11);
    endfunction

    function automatic logic [BANK_W-1:0] bank_last(logic [1:0] code);
        case (code)
            2'b00:   return 4'd3;
            2'b01:   return 4'd7;
            2'b10:   return 4'd15;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [RANK_W-1:0] rank_last(logic [1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b10:   return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [DIMM_W-1:0] dimm_last(logic [1:0] code);
        return (code == 2'b11) ? 2'd0 : code;
    endfunction

endpackage

// File: rtl/msw_geom_decode.sv
module msw_geom_decode
    import msw_pkg::*;
#(
    parameter int COL_BASE = 10,
    parameter int ROW_BASE = 12,
    parameter int COL_W    = COL_BASE + 2,
    parameter int ROW_W    = ROW_BASE + 4
) (
    input  geom_code_t         code,
    output logic [COL_W-1:0]   col_last,
    output logic [ROW_W-1:0]   row_last,
    output logic [BANK_W-1:0]  bank_lim,
    output logic [RANK_W-1:0]  rank_lim,
    output logic [DIMM_W-1:0]  dimm_lim,
    output logic               bad
);
    // A mask of n low ones is the last index of a power-of-two span.
    always_comb begin
        bad      = code_reserved(code);
        col_last = '0;
        row_last = '0;
        if (!bad) begin
            col_last = ~({COL_W{1'b1}} << (COL_BASE + int'(code.col)));
            row_last = ~({ROW_W{1'b1}} << (ROW_BASE + int'(code.row)));
        end
        bank_lim = bank_last(code.bank);
        rank_lim = rank_last(code.rank);
        dimm_lim = dimm_last(code.dimm);
    end
endmodule

// File: rtl/msw_wrap_counter.sv
module msw_wrap_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] last,
    output logic [W-1:0] val,
    output logic         at_last
);
    assign at_last = (val == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            val <= '0;
        end else if (inc) begin
            val <= at_last ? '0 : val + 1'b1;
        end
    end
endmodule

// File: rtl/msw_sweep_ctrl.sv
module msw_sweep_ctrl
    import msw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic scrub_mode,
    input  logic bad,
    input  logic fire,
    input  logic at_end,
    output logic load,
    output logic running,
    output logic done,
    output logic cfg_err,
    output logic zero_fill
);
    sweep_state_t state_q;

    assign running = (state_q == SW_RUN);
    assign load    = (state_q == SW_IDLE) && start && !bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SW_IDLE;
            done      <= 1'b0;
            cfg_err   <= 1'b0;
            zero_fill <= 1'b1;
        end else begin
            done <= fire && at_end;
            case (state_q)
                SW_IDLE: begin
                    if (start) begin
                        cfg_err <= bad;
                        if (!bad) begin
                            zero_fill <= !scrub_mode;
                            state_q   <= SW_RUN;
                        end
                    end
                end
                SW_RUN: begin
                    if (fire && at_end && !(!zero_fill && scrub_mode)) begin
                        state_q <= SW_IDLE;
                    end
                end
                default: state_q <= SW_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mem_init_sweeper.sv
module mem_init_sweeper
    import msw_pkg::*;
#(
    parameter int COL_BASE_LOG2 = 10,
    parameter int ROW_BASE_LOG2 = 12,
    localparam int COL_W = COL_BASE_LOG2 + 2,
    localparam int ROW_W = ROW_BASE_LOG2 + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              scrub_mode,
    input  logic [CODE_W-1:0] cfg,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [DIMM_W-1:0] req_dimm,
    output logic [RANK_W-1:0] req_rank,
    output logic [BANK_W-1:0] req_bank,
    output logic [ROW_W-1:0]  req_row,
    output logic [COL_W-1:0]  req_col,
    output logic              req_zero,
    output logic              done,
    output logic              busy,
    output logic              cfg_err
);
    geom_code_t         code_in;
    logic [COL_W-1:0]   d_col;
    logic [ROW_W-1:0]   d_row;
    logic [BANK_W-1:0]  d_bank;
    logic [RANK_W-1:0]  d_rank;
    logic [DIMM_W-1:0]  d_dimm;
    logic               d_bad;

    logic [COL_W-1:0]   l_col;
    logic [ROW_W-1:0]   l_row;
    logic [BANK_W-1:0]  l_bank;
    logic [RANK_W-1:0]  l_rank;
    logic [DIMM_W-1:0]  l_dimm;

    logic load, running, fire, at_end;
    logic col_at, row_at, bank_at, rank_at, dimm_at;
    logic inc_row, inc_bank, inc_rank, inc_dimm;

    assign code_in = geom_code_t'(cfg);

    msw_geom_decode #(
        .COL_BASE (COL_BASE_LOG2),
        .ROW_BASE (ROW_BASE_LOG2),
        .COL_W    (COL_W),
        .ROW_W    (ROW_W)
    ) u_decode (
        .code     (code_in),
        .col_last (d_col),
        .row_last (d_row),
        .bank_lim (d_bank),
        .rank_lim (d_rank),
        .dimm_lim (d_dimm),
        .bad      (d_bad)
    );

    msw_sweep_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .scrub_mode (scrub_mode),
        .bad        (d_bad),
        .fire       (fire),
        .at_end     (at_end),
        .load       (load),
        .running    (running),
        .done       (done),
        .cfg_err    (cfg_err),
        .zero_fill  (req_zero)
    );

    // Limits are frozen at launch so the live word cannot disturb a pass.
    always_ff @(posedge clk) begin
        if (rst) begin
            l_col  <= '0;
            l_row  <= '0;
            l_bank <= '0;
            l_rank <= '0;
            l_dimm <= '0;
        end else if (load) begin
            l_col  <= d_col;
            l_row  <= d_row;
            l_bank <= d_bank;
            l_rank <= d_rank;
            l_dimm <= d_dimm;
        end
    end

    assign fire     = running && req_ready;
    assign inc_row  = fire && col_at;
    assign inc_bank = inc_row && row_at;
    assign inc_rank = inc_bank && bank_at;
    assign inc_dimm = inc_rank && rank_at;
    assign at_end   = col_at && row_at && bank_at && rank_at && dimm_at;

    msw_wrap_counter #(.W(COL_W)) u_cnt_col (
        .clk(clk), .rst(rst), .clr(load), .inc(fire),
        .last(l_col), .val(req_col), .at_last(col_at)
    );
    msw_wrap_counter #(.W(ROW_W)) u_cnt_row (
        .clk(clk), .rst(rst), .clr(load), .inc(inc_row),
        .last(l_row), .val(req_row), .at_last(row_at)
    );
    msw_wrap_counter #(.W(BANK_W)) u_cnt_bank (
        .clk(clk), .rst(rst), .clr(load), .inc(inc_bank),
        .last(l_bank), .val(req_bank), .at_last(bank_at)
    );
    msw_wrap_counter #(.W(RANK_W)) u_cnt_rank (
        .clk(clk), .rst(rst), .clr(load), .inc(inc_rank),
        .last(l_rank), .val(req_rank), .at_last(rank_at)
    );
    msw_wrap_counter #(.W(DIMM_W)) u_cnt_dimm (
        .clk(clk), .rst(rst), .clr(load), .inc(inc_dimm),
        .last(l_dimm), .val(req_dimm), .at_last(dimm_at)
    );

    assign req_valid = running;
    assign busy      = running;
endmodule

// File: rtl/msw_checker.sv
module msw_checker
    import msw_pkg::*;
#(
    parameter int COL_W = 12,
    parameter int ROW_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              scrub_mode,
    input logic [CODE_W-1:0] cfg,
    input logic              req_ready,
    input logic              req_valid,
    input logic [ROW_W-1:0]  req_row,
    input logic [COL_W-1:0]  req_col,
    input logic              req_zero,
    input logic              done,
    input logic              busy,
    input logic              cfg_err
);
    assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_col) && $stable(req_row));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(req_valid && req_ready));

    assert_reject_reserved_R2: assert property (@(posedge clk) disable iff (rst)
        start && !busy && code_reserved(geom_code_t'(cfg)) |=> cfg_err && !req_valid);

    assert_col_steps_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> (req_col == $past(req_col) + 1'b1) || (req_col == '0));

    assert_row_moves_on_col_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> (req_row == $past(req_row)) || (req_col == '0));

    assert_zero_flag_mode_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (req_zero == !$past(scrub_mode)));
endmodule

bind mem_init_sweeper msw_checker #(
    .COL_W (COL_W),
    .ROW_W (ROW_W)
) u_msw_checker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .scrub_mode (scrub_mode),
    .cfg        (cfg),
    .req_ready  (req_ready),
    .req_valid  (req_valid),
    .req_row    (req_row),
    .req_col    (req_col),
    .req_zero   (req_zero),
    .done       (done),
    .busy       (busy),
    .cfg_err    (cfg_err)
);

// File: tb/mem_init_sweeper_tb.sv
module mem_init_sweeper_tb;
    localparam int CB = 1;
    localparam int RB = 1;
    localparam int CW = CB + 2;
    localparam int RW = RB + 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          scrub_mode = 1'b0;
    logic [10:0]   cfg = '0;
    logic          req_ready = 1'b0;
    logic          req_valid;
    logic [1:0]    req_dimm;
    logic [1:0]    req_rank;
    logic [3:0]    req_bank;
    logic [RW-1:0] req_row;
    logic [CW-1:0] req_col;
    logic          req_zero;
    logic          done;
    logic          busy;
    logic          cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    mem_init_sweeper #(.COL_BASE_LOG2(CB), .ROW_BASE_LOG2(RB)) u_dut (
        .clk(clk), .rst(rst), .start(start), .scrub_mode(scrub_mode), .cfg(cfg),
        .req_ready(req_ready), .req_valid(req_valid), .req_dimm(req_dimm),
        .req_rank(req_rank), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_zero(req_zero), .done(done), .busy(busy),
        .cfg_err(cfg_err)
    );

    // cfg = {dimm[1:0], rank[1:0], bank[1:0], row[2:0], col[1:0]}
    typedef struct packed {
        logic [10:0] cfg;
        int nc; int nr; int nb; int nk; int nd;
        bit stall;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{11'b00_00_00_000_00, 2, 2, 4, 1, 1, 1'b0},
        '{11'b00_00_00_100_10, 8, 32, 4, 1, 1, 1'b0},
        '{11'b10_10_10_001_01, 4, 4, 16, 4, 3, 1'b0},
        '{11'b01_01_01_010_00, 2, 8, 8, 2, 2, 1'b1},
        '{11'b10_10_10_100_10, 8, 32, 16, 4, 3, 1'b0}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
            $finish;
        end
    end

    // Called at a negedge; returns at a negedge.
    task automatic run_sweep(input logic [10:0] c, input int nc, input int nr,
                             input int nb, input int nk, input int nd,
                             input bit stall, input bit scrub, input bit do_start,
                             input bit exp_zero, input bit expect_more,
                             input bit disturb, input string tag);
        int total = nc * nr * nb * nk * nd;
        int seen = 0, mism = 0, zbad = 0, guard = 0;
        int mc = 0, mr = 0, mb = 0, mk = 0, md = 0;
        int first_act = 0, first_exp = 0;
        bit poked = 0;
        bit d1, d2, v1, b1;
        scrub_mode = scrub;
        if (do_start) begin
            cfg = c;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            // R10 / R4: valid one cycle after start, error flag cleared
            chk(req_valid && !cfg_err, "R10", {tag, " start"},
                {req_valid, cfg_err}, 2);
        end
        while (seen < total && guard < 120000) begin
            if (stall) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                req_ready = lfsr[0];
            end else begin
                req_ready = 1'b1;
            end
            if (disturb) begin
                if (seen == 5 && !poked) begin
                    start = 1'b1;
                    cfg = VECS[2].cfg;
                    poked = 1;
                end else begin
                    start = 1'b0;
                end
            end
            if (req_valid && req_ready) begin
                if (mism == 0 && (req_col != mc || req_row != mr || req_bank != mb ||
                                  req_rank != mk || req_dimm != md)) begin
                    first_act = {req_dimm, req_rank, req_bank, 11'(req_row), 11'(req_col)};
                    first_exp = {md[1:0], mk[1:0], mb[3:0], 11'(mr), 11'(mc)};
                end
                if (req_col != mc || req_row != mr || req_bank != mb ||
                    req_rank != mk || req_dimm != md) mism++;
                if (req_zero != exp_zero) zbad++;
                seen++;
                mc++;
                if (mc == nc) begin
                    mc = 0; mr++;
                    if (mr == nr) begin
                        mr = 0; mb++;
                        if (mb == nb) begin
                            mb = 0; mk++;
                            if (mk == nk) begin mk = 0; md++; end
                        end
                    end
                end
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        d1 = done; v1 = req_valid; b1 = busy;
        req_ready = 1'b0;
        @(negedge clk);
        d2 = done;
        // R3 order, R1 decode sizes, R4 stall holding, R8 disturbance ignored
        chk(mism == 0, disturb ? "R8" : (stall ? "R4" : "R3"), {tag, " address order"},
            first_act, first_exp);
        chk(seen == total, "R1", {tag, " address count"}, seen, total);
        chk(zbad == 0, exp_zero ? "R5" : "R7", {tag, " zero flag"}, zbad, 0);
        chk(d1 && !d2 && v1 == expect_more && b1 == expect_more,
            expect_more ? "R7" : "R6", {tag, " done pulse"},
            {d1, d2, v1, b1}, {1'b1, 1'b0, expect_more, expect_more});
    endtask

    task automatic try_bad(input logic [10:0] c, input string tag);
        @(negedge clk);
        cfg = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: reserved code rejected
        chk(cfg_err && !req_valid && !busy, "R2", tag, {cfg_err, req_valid, busy}, 3'b100);
        @(negedge clk);
        chk(!req_valid && !done, "R2", {tag, " stays idle"}, {req_valid, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!req_valid && !done && !busy && !cfg_err, "R9", "in reset",
            {req_valid, done, busy, cfg_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_valid && !done && !busy && !cfg_err, "R9", "after reset",
            {req_valid, done, busy, cfg_err}, 0);

        for (int i = 0; i < 5; i++) begin
            run_sweep(VECS[i].cfg, VECS[i].nc, VECS[i].nr, VECS[i].nb, VECS[i].nk,
                      VECS[i].nd, VECS[i].stall, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0,
                      $sformatf("vec%0d", i));
        end

        // R2: each reserved field value
        try_bad(11'b00_00_00_000_11, "col code 3");
        try_bad(11'b00_00_00_101_00, "row code 5");
        try_bad(11'b00_00_00_111_00, "row code 7");
        try_bad(11'b00_00_11_000_00, "bank code 3");
        try_bad(11'b00_11_00_000_00, "rank code 3");
        try_bad(11'b11_00_00_000_00, "dimm code 3");

        // R10 clears error; R8 start and cfg change mid-sweep ignored
        run_sweep(VECS[0].cfg, 2, 2, 4, 1, 1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                  "disturbed");

        // R7: patrol mode, restart while held high, stop when dropped
        run_sweep(VECS[0].cfg, 2, 2, 4, 1, 1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
                  "patrol pass1");
        run_sweep(VECS[0].cfg, 2, 2, 4, 1, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                  "patrol pass2");

        summary();
        $finish;
    end
endmodule